// File: doc/BRIEF.md
# USB Data Packet CRC16 Checker

This block computes the 16-bit data-packet checksum over a received byte stream and judges the packet at its end. A receive front end feeds it the bytes that follow the packet identifier, one byte per strobe, including the two checksum bytes at the tail. A start strobe opens a packet and an end strobe closes it. One clock after the end strobe the block reports whether the packet is intact. A packet that fails the check is meant to be dropped without a handshake.

Each byte is not folded into the checksum in the cycle it arrives. It is parked and folded in when the next byte or the end strobe arrives. The register is therefore loaded at start with a preset value, chosen so that folding an implicit zero byte first produces the standard all-ones start value. The running output then always covers every byte except the one still parked.

Top module: `usb_crc16_chk`

## Requirements
- R1: After reset, crc_o is 0xFE54 and crc_ok_o is 0. No packet is open.
- R2: sop_i has priority over every other input. One clock after it, crc_o is 0xFE54, crc_ok_o is 0, a packet is open, and an implicit zero byte is parked.
- R3: An accepted byte folds the parked byte b into the register and then parks itself. The fold is crc' = T[crc[7:0] xor b] xor (crc >> 8), where T[i] is i shifted right eight times with 0xA001 xored in whenever the bit shifted out is 1. One clock after the first real byte, crc_o is therefore 0xFFFF.
- R4: One clock after the k-th accepted byte of a packet, crc_o equals the checksum of the first k-1 bytes. That checksum starts from 0xFFFF and takes each byte LSB first with the reflected polynomial 0xA001.
- R5: eop_i during an open packet folds the parked byte and closes the packet. One clock later, crc_o holds the final remainder over all accepted bytes, and crc_ok_o is 1 exactly when that remainder is 0xB001.
- R6: A byte strobed in the same cycle as eop_i is dropped. It takes no part in the remainder.
- R7: While no packet is open, data_vld_i and eop_i have no effect. crc_o and crc_ok_o hold their values until the next sop_i.
- R8: Idle cycles between bytes of an open packet leave crc_o and crc_ok_o unchanged and do not alter the final result.
- R9: For a packet whose data bytes are followed by the complement of their checksum (low byte first, then high byte), crc_ok_o is 1. This includes a packet with no data bytes. Corrupting any bit gives crc_ok_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start of packet: preload and open |
| data_vld_i | input | 1 | Byte strobe |
| data_i | input | 8 | Received byte after the packet identifier |
| eop_i | input | 1 | End of packet: fold last byte and judge |
| crc_o | output | 16 | Running checksum register |
| crc_ok_o | output | 1 | Packet remainder matched 0xB001 |

## Verification
The hardest situation to reach is the cycle where the deferred byte and the end strobe interact. This covers the final fold triggered by eop_i alone, and a byte strobed together with eop_i that must be discarded. The stimulus reaches it by ending otherwise valid packets both with a clean end strobe and with a stray byte on the end cycle, and by using packets of zero, one and many data bytes, so that the parked byte is the virtual zero, a data byte or a checksum byte. A restart in mid-packet and strobes sent after the close check that the parked state is cleared and that the block ignores input while closed.

// File: rtl/usb_crc16_pkg.sv
package usb_crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] dbyte_t;

  // Reflected byte-wide table entry: shift right BYTE_W times
  function automatic crc_t tbl_entry(input dbyte_t idx, input crc_t poly);
    crc_t c;
    c = crc_t'(idx);
    for (int k = 0; k < BYTE_W; k++) begin
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/usb_crc16_lut.sv
module usb_crc16_lut
  import usb_crc16_pkg::*;
#(
  parameter crc_t POLY = 16'hA001
) (
  input  dbyte_t idx_i,
  output crc_t   val_o
);
  localparam int ENTRIES = 1 << BYTE_W;

  crc_t tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign tbl[i] = tbl_entry(dbyte_t'(i), POLY);
  end

  assign val_o = tbl[idx_i];
endmodule

// File: rtl/usb_crc16_fold.sv
module usb_crc16_fold
  import usb_crc16_pkg::*;
#(
  parameter crc_t POLY = 16'hA001
) (
  input  crc_t   crc_i,
  input  dbyte_t data_i,
  output crc_t   crc_o
);
  dbyte_t idx;
  crc_t   tval;

  assign idx = crc_i[BYTE_W-1:0] ^ data_i;

  usb_crc16_lut #(.POLY(POLY)) u_lut (
    .idx_i(idx),
    .val_o(tval)
  );

  assign crc_o = tval ^ (crc_i >> BYTE_W);
endmodule

// File: rtl/usb_crc16_seq.sv
module usb_crc16_seq
  import usb_crc16_pkg::*;
#(
  parameter crc_t PRELOAD = 16'hFE54,
  parameter crc_t RESIDUE = 16'hB001
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sop_i,
  input  logic   data_vld_i,
  input  dbyte_t data_i,
  input  logic   eop_i,
  input  crc_t   fold_i,
  output crc_t   crc_o,
  output dbyte_t pend_o,
  output logic   active_o,
  output logic   ok_o
);
  crc_t   crc_q;
  dbyte_t pend_q;
  logic   active_q;
  logic   ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q    <= PRELOAD;
      pend_q   <= '0;
      active_q <= 1'b0;
      ok_q     <= 1'b0;
    end else if (sop_i) begin
      crc_q    <= PRELOAD;
      pend_q   <= '0;   // virtual zero byte
      active_q <= 1'b1;
      ok_q     <= 1'b0;
    end else if (active_q && eop_i) begin
      crc_q    <= fold_i;
      active_q <= 1'b0;
      ok_q     <= (fold_i == RESIDUE);
    end else if (active_q && data_vld_i) begin
      crc_q  <= fold_i;
      pend_q <= data_i;
    end
  end

  assign crc_o    = crc_q;
  assign pend_o   = pend_q;
  assign active_o = active_q;
  assign ok_o     = ok_q;
endmodule

// File: rtl/usb_crc16_chk.sv
module usb_crc16_chk
  import usb_crc16_pkg::*;
#(
  parameter crc_t POLY    = 16'hA001,
  parameter crc_t PRELOAD = 16'hFE54,
  parameter crc_t RESIDUE = 16'hB001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sop_i,
  input  logic              data_vld_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              eop_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_ok_o
);
  crc_t   crc_q;
  crc_t   fold_nxt;
  dbyte_t pend_q;
  logic   pkt_active;

  usb_crc16_fold #(.POLY(POLY)) u_fold (
    .crc_i (crc_q),
    .data_i(pend_q),
    .crc_o (fold_nxt)
  );

  usb_crc16_seq #(.PRELOAD(PRELOAD), .RESIDUE(RESIDUE)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sop_i     (sop_i),
    .data_vld_i(data_vld_i),
    .data_i    (data_i),
    .eop_i     (eop_i),
    .fold_i    (fold_nxt),
    .crc_o     (crc_q),
    .pend_o    (pend_q),
    .active_o  (pkt_active),
    .ok_o      (crc_ok_o)
  );

  assign crc_o = crc_q;
endmodule

// File: rtl/usb_crc16_chk_sva.sv
module usb_crc16_chk_sva
  import usb_crc16_pkg::*;
#(
  parameter crc_t PRELOAD = 16'hFE54,
  parameter crc_t RESIDUE = 16'hB001
) (
  input logic   clk_i,
  input logic   rst_ni,
  input logic   sop_i,
  input logic   data_vld_i,
  input logic   eop_i,
  input crc_t   crc_o,
  input logic   crc_ok_o,
  input logic   active_i
);
  p_sop_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i |=> (crc_o == PRELOAD) && !crc_ok_o);

  p_first_fold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i ##1 (data_vld_i && !eop_i && !sop_i) |=> (crc_o == 16'hFFFF));

  p_ok_residue_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && eop_i && !sop_i) |=> (crc_ok_o == (crc_o == RESIDUE)));

  p_ok_after_eop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(crc_ok_o) |-> $past(eop_i));

  p_closed_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !sop_i) |=> $stable(crc_o) && $stable(crc_ok_o));

  p_gap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !sop_i && !data_vld_i && !eop_i) |=> $stable(crc_o) && $stable(crc_ok_o));
endmodule

bind usb_crc16_chk usb_crc16_chk_sva #(.PRELOAD(PRELOAD), .RESIDUE(RESIDUE)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sop_i     (sop_i),
  .data_vld_i(data_vld_i),
  .eop_i     (eop_i),
  .crc_o     (crc_o),
  .crc_ok_o  (crc_ok_o),
  .active_i  (pkt_active)
);

// File: tb/tb_usb_crc16_chk.sv
module tb_usb_crc16_chk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop = 1'b0;
  logic        vld = 1'b0;
  logic [7:0]  din = 8'h00;
  logic        eop = 1'b0;
  logic [15:0] crc;
  logic        ok;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {logic ok; logic [15:0] crc; string tag;} exp_t;
  exp_t exp_q[$];
  logic [7:0] pkt[$];
  logic [7:0] img[$];

  always #5 clk = ~clk;

  usb_crc16_chk dut (
    .clk_i(clk), .rst_ni(rst_n), .sop_i(sop), .data_vld_i(vld),
    .data_i(din), .eop_i(eop), .crc_o(crc), .crc_ok_o(ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bitwise reflected reference from 0xFFFF
  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[i]) begin
      for (int k = 0; k < 8; k++) begin
        logic fb = c[0] ^ q[i][k];
        c = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  // Monitor: pops expected judgement one clock after an accepted end strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && eop && exp_q.size() > 0) begin
        exp_t e;
        @(negedge clk);
        e = exp_q.pop_front();
        chk({e.tag, " R5 remainder"}, 32'(crc), 32'(e.crc));
        chk({e.tag, " R5 ok"}, 32'(ok), 32'(e.ok));
      end
    end
  end

  task automatic start_pkt();
    sop = 1'b1;
    @(negedge clk);
    sop = 1'b0;
    pkt.delete();
    chk("R2 preload", 32'(crc), 32'h0000FE54);
    chk("R2 ok cleared", 32'(ok), 32'h0);
  endtask

  task automatic send_byte(input logic [7:0] b, input int gap);
    logic [15:0] held;
    vld = 1'b1;
    din = b;
    @(negedge clk);
    vld = 1'b0;
    // crc covers all bytes except the one just parked (R3 first fold, R4 running)
    chk(pkt.size() == 0 ? "R3 first fold" : "R4 running", 32'(crc), 32'(ref_crc(pkt)));
    pkt.push_back(b);
    if (gap > 0) begin
      held = crc;
      repeat (gap) @(negedge clk);
      chk("R8 gap hold", 32'(crc), 32'(held));
    end
  endtask

  task automatic end_pkt(input logic good, input logic stray, input string tag);
    exp_t e;
    e.ok = good;
    e.crc = ref_crc(pkt);
    e.tag = tag;
    exp_q.push_back(e);
    eop = 1'b1;
    if (stray) begin
      vld = 1'b1;   // R6: must be dropped
      din = 8'hA5;
    end
    @(negedge clk);
    eop = 1'b0;
    vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic build_good(input int n, input int seed);
    logic [15:0] c;
    img.delete();
    for (int i = 0; i < n; i++) img.push_back(8'((i * 37 + seed * 11) ^ 8'h5C));
    c = ~ref_crc(img);
    img.push_back(c[7:0]);
    img.push_back(c[15:8]);
  endtask

  task automatic run_pkt(input logic good, input int gap, input logic stray, input string tag);
    start_pkt();
    foreach (img[i]) send_byte(img[i], gap);
    end_pkt(good, stray, tag);
  endtask

  task automatic closed_strobe(input logic with_eop);
    logic [15:0] c0;
    logic        k0;
    c0 = crc;
    k0 = ok;
    vld = 1'b1;
    din = 8'h3C;
    eop = with_eop;
    @(negedge clk);
    vld = 1'b0;
    eop = 1'b0;
    chk("R7 crc held", 32'(crc), 32'(c0));
    chk("R7 ok held", 32'(ok), 32'(k0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset crc", 32'(crc), 32'h0000FE54);
    chk("R1 reset ok", 32'(ok), 32'h0);
    closed_strobe(1'b0);
    closed_strobe(1'b1);

    build_good(0, 1);  run_pkt(1'b1, 0, 1'b0, "R9 empty");
    build_good(1, 2);  run_pkt(1'b1, 0, 1'b0, "R9 len1");
    build_good(3, 3);  run_pkt(1'b1, 0, 1'b0, "R9 len3");
    build_good(8, 4);  run_pkt(1'b1, 2, 1'b0, "R8 gaps");
    build_good(20, 5); run_pkt(1'b1, 0, 1'b0, "R9 len20");
    closed_strobe(1'b0);

    build_good(5, 6);
    img[2] = img[2] ^ 8'h10;
    run_pkt(1'b0, 0, 1'b0, "R9 corrupt");
    closed_strobe(1'b1);

    build_good(4, 7);
    img[5] = img[5] ^ 8'h01;
    run_pkt(1'b0, 1, 1'b0, "R9 bad crc field");

    build_good(6, 8); run_pkt(1'b1, 0, 1'b1, "R6 stray byte");

    // restart mid-packet
    start_pkt();
    send_byte(8'h11, 0);
    send_byte(8'h22, 0);
    send_byte(8'h33, 0);
    build_good(7, 9); run_pkt(1'b1, 0, 1'b0, "R2 restart");

    repeat (3) @(negedge clk);
    chk("R5 queue drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule